// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits beside the main command scheduler of a two-bank synchronous DRAM controller and keeps the device's contents alive. A free-running interval timer produces one refresh obligation per slot. Each slot is the refresh window divided evenly across the required number of refreshes, measured in clock cycles and rounded down. Missed slots are remembered as a small debt. While anything is owed, the block raises a request toward the main scheduler. That scheduler closes its rows and then signals that both banks are idle. The block then takes the command bus, issues an auto-refresh and holds no-operation commands for the recovery time. If more refreshes are owed, it issues them back to back.

On a low-power request, the block waits for idle banks in the same way. It then issues the self-refresh entry command, which drops the clock-enable line, and keeps that line low for as long as the request stays up. It never holds it low for less than the minimum residency time. Exit raises clock-enable under a no-operation command and waits out the recovery time before the bus is handed back. Entering self-refresh forgives any debt and restarts the interval timer.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and after reset, with no request pending, the block drives a deselect (cs_n_o=1, ras_n_o=1, cas_n_o=1, we_n_o=1, dsf_o=0) with cke_o=1, and ref_req_o, bus_own_o and sr_ack_o are low.
- R2: The refresh slot is INTERVAL = floor(CLK_MHZ*WINDOW_US/REFRESHES) cycles. With banks idle throughout, the first auto-refresh appears INTERVAL+2 cycles after reset is released, and later ones follow exactly INTERVAL cycles apart.
- R3: An auto-refresh is cs_n_o=0, ras_n_o=0, cas_n_o=0, we_n_o=1, dsf_o=0 with cke_o=1, and cke_o was 1 in the cycle before.
- R4: No auto-refresh is issued while banks_idle_i is low and the block does not own the bus; ref_req_o stays high, with the bus deselected, for as long as a refresh is owed and not yet granted.
- R5: Up to MAX_DEBT owed refreshes are remembered, and further missed slots are dropped; once granted, all remembered refreshes are issued in one burst.
- R6: Each auto-refresh is followed by TRP_CYC cycles of no-operation (cs_n_o=0, ras_n_o=1, cas_n_o=1, we_n_o=1) with bus_own_o high, so refreshes in a burst are TRP_CYC+1 cycles apart.
- R7: Self-refresh entry uses the auto-refresh encoding with cke_o=0, and cke_o was 1 in the cycle before.
- R8: While sr_req_i stays high after entry, cke_o stays 0, cs_n_o stays 1, sr_ack_o stays 1 and no auto-refresh is issued.
- R9: cke_o stays low for at least TRAS_CYC+1 cycles counting the entry cycle, and for exactly that many when sr_req_i is withdrawn right after entry.
- R10: Exit raises cke_o together with a no-operation. TRP_CYC further no-operation cycles follow with bus_own_o high, and then the bus is released with a deselect.
- R11: Self-refresh clears the debt and restarts the slot timer, so with banks idle the first auto-refresh after exit appears exactly INTERVAL+2 cycles after cke_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle_i | input | 1 | Main scheduler reports both banks precharged and the bus free |
| sr_req_i | input | 1 | Request to enter, and stay in, self-refresh |
| ref_req_o | output | 1 | Block needs the bus; main scheduler should idle the banks |
| bus_own_o | output | 1 | Block is driving the command bus |
| sr_ack_o | output | 1 | Device is resting in self-refresh |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dsf_o | output | 1 | Special-function select, held low |
| cke_o | output | 1 | Clock enable |

## Verification
The assertions watch local command rules on every cycle. They check the refresh and entry encodings against the previous clock-enable level, and the no-operation cycle after each refresh and at exit. They also confirm that a refresh follows either idle banks or bus ownership, that clock-enable never drops for a single cycle, that self-refresh stays quiet, and that the debt stays within its cap. Properties spanning many cycles are left to the bench scenarios: the exact slot spacing, the burst length after a long denial, the minimum residency, and the timer restart after exit.

// File: rtl/ref_pkg.sv
package ref_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_WAIT = 3'd1,
        ST_AREF = 3'd2,
        ST_TRP  = 3'd3,
        ST_SRE  = 3'd4,
        ST_SELF = 3'd5,
        ST_SRX  = 3'd6
    } ref_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dsf;
        logic cke;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                        we_n: 1'b1, dsf: 1'b0, cke: 1'b1};
    localparam dram_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                        we_n: 1'b1, dsf: 1'b0, cke: 1'b1};
    localparam dram_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0,
                                        we_n: 1'b1, dsf: 1'b0, cke: 1'b1};
    localparam dram_cmd_t CMD_SRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0,
                                        we_n: 1'b1, dsf: 1'b0, cke: 1'b0};
    localparam dram_cmd_t CMD_SLEEP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                        we_n: 1'b1, dsf: 1'b0, cke: 1'b0};

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic reload_i,
    output logic tick_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = 1'b0;
        if (reload_i) begin
            tmr_d.cnt = RELOAD;
        end else if (!hold_i) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.cnt = RELOAD;
                tick_o    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt <= RELOAD;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
    parameter int MAX_DEBT = 4,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_i,
    input  logic          pay_i,
    input  logic          clear_i,
    output logic [DW-1:0] debt_o,
    output logic          pending_o
);
    localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

    typedef struct packed {
        logic [DW-1:0] debt;
    } debt_t;

    debt_t dbt_d, dbt_q;

    always_comb begin
        dbt_d = dbt_q;
        if (clear_i) begin
            dbt_d.debt = '0;
        end else begin
            unique case ({add_i, pay_i})
                2'b10: if (dbt_q.debt < CAP) dbt_d.debt = dbt_q.debt + 1'b1;
                2'b01: if (dbt_q.debt != '0) dbt_d.debt = dbt_q.debt - 1'b1;
                default: dbt_d.debt = dbt_q.debt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbt_q.debt <= '0;
        end else begin
            dbt_q <= dbt_d;
        end
    end

    assign debt_o    = dbt_q.debt;
    assign pending_o = (dbt_q.debt != '0);

endmodule

// File: rtl/ref_cmd_enc.sv
module ref_cmd_enc
    import ref_pkg::*;
(
    input  ref_state_e state_i,
    output dram_cmd_t  cmd_o,
    output logic       ref_req_o,
    output logic       bus_own_o,
    output logic       sr_ack_o
);
    always_comb begin
        cmd_o     = CMD_DESEL;
        ref_req_o = 1'b0;
        bus_own_o = 1'b0;
        sr_ack_o  = 1'b0;
        unique case (state_i)
            ST_RUN: begin
                cmd_o = CMD_DESEL;
            end
            ST_WAIT: begin
                cmd_o     = CMD_DESEL;
                ref_req_o = 1'b1;
            end
            ST_AREF: begin
                cmd_o     = CMD_AREF;
                bus_own_o = 1'b1;
            end
            ST_TRP, ST_SRX: begin
                cmd_o     = CMD_NOP;
                bus_own_o = 1'b1;
            end
            ST_SRE: begin
                cmd_o     = CMD_SRE;
                bus_own_o = 1'b1;
            end
            ST_SELF: begin
                cmd_o     = CMD_SLEEP;
                bus_own_o = 1'b1;
                sr_ack_o  = 1'b1;
            end
            default: begin
                cmd_o = CMD_DESEL;
            end
        endcase
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import ref_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int WINDOW_US = 32000,
    parameter int REFRESHES = 2048,
    parameter int TRP_CYC   = 3,
    parameter int TRAS_CYC  = 6,
    parameter int MAX_DEBT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle_i,
    input  logic sr_req_i,
    output logic ref_req_o,
    output logic bus_own_o,
    output logic sr_ack_o,
    output logic cs_n_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic dsf_o,
    output logic cke_o
);
    localparam int INTERVAL = (CLK_MHZ * WINDOW_US) / REFRESHES;
    localparam int TMAX     = (TRP_CYC > TRAS_CYC) ? TRP_CYC : TRAS_CYC;
    localparam int TW       = (TMAX > 2) ? $clog2(TMAX) : 1;
    localparam int DW       = $clog2(MAX_DEBT + 1);
    localparam logic [TW-1:0] TRP_LOAD  = TW'(TRP_CYC - 1);
    localparam logic [TW-1:0] TRAS_LOAD = TW'(TRAS_CYC - 1);

    typedef struct packed {
        ref_state_e    state;
        logic [TW-1:0] tmr;
    } fsm_t;

    fsm_t      fsm_d, fsm_q;
    logic      slot_tick;
    logic      owed;
    logic [DW-1:0] debt_q;
    dram_cmd_t cmd;

    ref_interval_timer #(
        .INTERVAL (INTERVAL)
    ) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (fsm_q.state == ST_SELF),
        .reload_i (fsm_q.state == ST_SRE),
        .tick_o   (slot_tick)
    );

    ref_debt_ctr #(
        .MAX_DEBT (MAX_DEBT)
    ) i_debt (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_i     (slot_tick),
        .pay_i     (fsm_q.state == ST_AREF),
        .clear_i   (fsm_q.state == ST_SRE),
        .debt_o    (debt_q),
        .pending_o (owed)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_RUN: begin
                if (sr_req_i || owed) fsm_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (banks_idle_i) begin
                    if (sr_req_i)  fsm_d.state = ST_SRE;
                    else if (owed) fsm_d.state = ST_AREF;
                    else           fsm_d.state = ST_RUN;
                end else if (!sr_req_i && !owed) begin
                    fsm_d.state = ST_RUN;
                end
            end
            ST_AREF: begin
                fsm_d.state = ST_TRP;
                fsm_d.tmr   = TRP_LOAD;
            end
            ST_TRP: begin
                if (fsm_q.tmr != '0) begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end else if (sr_req_i) begin
                    fsm_d.state = ST_SRE;
                end else if (owed) begin
                    fsm_d.state = ST_AREF;
                end else begin
                    fsm_d.state = ST_RUN;
                end
            end
            ST_SRE: begin
                fsm_d.state = ST_SELF;
                fsm_d.tmr   = TRAS_LOAD;
            end
            ST_SELF: begin
                if (fsm_q.tmr != '0) begin
                    fsm_d.tmr = fsm_q.tmr - 1'b1;
                end else if (!sr_req_i) begin
                    fsm_d.state = ST_SRX;
                end
            end
            ST_SRX: begin
                fsm_d.state = ST_TRP;
                fsm_d.tmr   = TRP_LOAD;
            end
            default: begin
                fsm_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state <= ST_RUN;
            fsm_q.tmr   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    ref_cmd_enc i_enc (
        .state_i   (fsm_q.state),
        .cmd_o     (cmd),
        .ref_req_o (ref_req_o),
        .bus_own_o (bus_own_o),
        .sr_ack_o  (sr_ack_o)
    );

    assign cs_n_o  = cmd.cs_n;
    assign ras_n_o = cmd.ras_n;
    assign cas_n_o = cmd.cas_n;
    assign we_n_o  = cmd.we_n;
    assign dsf_o   = cmd.dsf;
    assign cke_o   = cmd.cke;

endmodule

// File: rtl/ref_sched_checker.sv
module ref_sched_checker #(
    parameter int MAX_DEBT = 4,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          banks_idle_i,
    input logic          ref_req_o,
    input logic          bus_own_o,
    input logic          sr_ack_o,
    input logic          cs_n_o,
    input logic          ras_n_o,
    input logic          cas_n_o,
    input logic          we_n_o,
    input logic          dsf_o,
    input logic          cke_o,
    input logic [DW-1:0] debt
);
    logic refresh_cmd;
    logic nop_cmd;
    logic entry_cmd;

    assign refresh_cmd = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o && !dsf_o && cke_o;
    assign nop_cmd     = !cs_n_o && ras_n_o && cas_n_o && we_n_o && cke_o;
    assign entry_cmd   = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o && !dsf_o;

    p_aref_prev_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cmd |-> $past(cke_o));

    p_aref_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cmd |-> ($past(banks_idle_i) || $past(bus_own_o)));

    p_req_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (cs_n_o && !bus_own_o));

    p_debt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(MAX_DEBT));

    p_aref_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cmd |=> (nop_cmd && bus_own_o));

    p_entry_enc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> entry_cmd);

    p_self_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack_o |-> (!cke_o && cs_n_o));

    p_cke_low_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |=> !cke_o);

    p_exit_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (nop_cmd && bus_own_o));

endmodule

bind dram_refresh_sched ref_sched_checker #(
    .MAX_DEBT (MAX_DEBT)
) i_ref_sched_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .banks_idle_i (banks_idle_i),
    .ref_req_o    (ref_req_o),
    .bus_own_o    (bus_own_o),
    .sr_ack_o     (sr_ack_o),
    .cs_n_o       (cs_n_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .dsf_o        (dsf_o),
    .cke_o        (cke_o),
    .debt         (debt_q)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 10;
    localparam int WINDOW_US  = 128;
    localparam int REFRESHES  = 32;
    localparam int TRP_CYC    = 3;
    localparam int TRAS_CYC   = 6;
    localparam int MAX_DEBT   = 3;
    localparam int INTERVAL   = (CLK_MHZ * WINDOW_US) / REFRESHES;

    logic clk = 1'b0;
    logic rst_n;
    logic banks_idle_i;
    logic sr_req_i;
    logic ref_req_o, bus_own_o, sr_ack_o;
    logic cs_n_o, ras_n_o, cas_n_o, we_n_o, dsf_o, cke_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic prev_cke = 1'b1;

    dram_refresh_sched #(
        .CLK_MHZ   (CLK_MHZ),
        .WINDOW_US (WINDOW_US),
        .REFRESHES (REFRESHES),
        .TRP_CYC   (TRP_CYC),
        .TRAS_CYC  (TRAS_CYC),
        .MAX_DEBT  (MAX_DEBT)
    ) i_dram_refresh_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .banks_idle_i (banks_idle_i),
        .sr_req_i     (sr_req_i),
        .ref_req_o    (ref_req_o),
        .bus_own_o    (bus_own_o),
        .sr_ack_o     (sr_ack_o),
        .cs_n_o       (cs_n_o),
        .ras_n_o      (ras_n_o),
        .cas_n_o      (cas_n_o),
        .we_n_o       (we_n_o),
        .dsf_o        (dsf_o),
        .cke_o        (cke_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        prev_cke = cke_o;
        @(negedge clk);
        cyc++;
    endtask

    function automatic bit is_aref();
        return !cs_n_o && !ras_n_o && !cas_n_o && cke_o;
    endfunction

    function automatic bit is_nop();
        return !cs_n_o && ras_n_o && cas_n_o && we_n_o && cke_o;
    endfunction

    function automatic int cmd_bits();
        return {cs_n_o, ras_n_o, cas_n_o, we_n_o, dsf_o, cke_o};
    endfunction

    task automatic wait_aref(input int limit, output bit found);
        found = 1'b0;
        for (int i = 0; i < limit; i++) begin
            step();
            if (is_aref()) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_recovery(input string req);
        for (int k = 0; k < TRP_CYC; k++) begin
            step();
            check(is_nop() && bus_own_o, req, "no-operation during recovery",
                  cmd_bits(), 6'b011101);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit found;
        int last;
        int n;
        int gap_bad;
        int bad;
        int rise;
        int low;

        rst_n = 1'b0;
        banks_idle_i = 1'b1;
        sr_req_i = 1'b0;
        repeat (3) step();

        // R1: reset state
        check(cmd_bits() == 6'b111101, "R1", "reset command bus", cmd_bits(), 6'b111101);
        check(!ref_req_o && !bus_own_o && !sr_ack_o, "R1", "reset handshake",
              {ref_req_o, bus_own_o, sr_ack_o}, 0);

        rst_n = 1'b1;
        cyc = 0;

        // R2: first refresh timing, R3 encoding
        wait_aref(INTERVAL + 10, found);
        check(cyc == INTERVAL + 2, "R2", "first refresh cycle", cyc, INTERVAL + 2);
        check(we_n_o && !dsf_o && prev_cke, "R3", "refresh encoding we/dsf/prev cke",
              {we_n_o, dsf_o, prev_cke}, 3'b101);
        last = cyc;
        check_recovery("R6");
        step();
        check(!bus_own_o && cs_n_o && !ref_req_o, "R1", "bus released after recovery",
              {bus_own_o, cs_n_o, ref_req_o}, 3'b010);

        // R2: steady spacing
        for (int r = 0; r < 3; r++) begin
            wait_aref(INTERVAL + 10, found);
            check(found && (cyc - last == INTERVAL), "R2", "refresh spacing",
                  cyc - last, INTERVAL);
            last = cyc;
        end
        check_recovery("R6");

        // R4: denial of the bus
        banks_idle_i = 1'b0;
        n = 0;
        for (int i = 0; i < 4 * INTERVAL + 5; i++) begin
            step();
            if (is_aref()) n++;
        end
        check(n == 0, "R4", "refreshes while banks busy", n, 0);
        check(ref_req_o && cs_n_o, "R4", "request held with deselect",
              {ref_req_o, cs_n_o}, 2'b11);

        // R5/R6: burst payback
        banks_idle_i = 1'b1;
        n = 0;
        gap_bad = 0;
        last = -1;
        for (int i = 0; i < 24; i++) begin
            step();
            if (is_aref()) begin
                n++;
                if (last >= 0 && cyc - last != TRP_CYC + 1) gap_bad++;
                last = cyc;
            end
        end
        check(n == MAX_DEBT, "R5", "burst length after denial", n, MAX_DEBT);
        check(gap_bad == 0, "R6", "burst spacing violations", gap_bad, 0);

        // R7: self-refresh entry
        sr_req_i = 1'b1;
        for (int i = 0; i < 30 && cke_o; i++) step();
        check(!cke_o && cmd_bits() == 6'b000100, "R7", "entry encoding",
              cmd_bits(), 6'b000100);
        check(prev_cke, "R7", "clock enable high before entry", prev_cke, 1);

        // R8: held in self-refresh
        bad = 0;
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            step();
            if (cke_o || !cs_n_o || !sr_ack_o || is_aref()) bad++;
        end
        check(bad == 0, "R8", "cycles leaving quiet self-refresh", bad, 0);

        // R10: exit
        sr_req_i = 1'b0;
        for (int i = 0; i < 10 && !cke_o; i++) step();
        rise = cyc;
        check(cke_o && is_nop() && bus_own_o, "R10", "exit command",
              cmd_bits(), 6'b011101);
        check_recovery("R10");
        step();
        check(!bus_own_o && cs_n_o && cke_o, "R10", "bus released after exit",
              {bus_own_o, cs_n_o, cke_o}, 3'b011);

        // R11: timer restarted and debt cleared
        wait_aref(INTERVAL + 10, found);
        check(found && (cyc - rise == INTERVAL + 2), "R11", "first refresh after exit",
              cyc - rise, INTERVAL + 2);
        check_recovery("R6");

        // R9: minimum residency
        sr_req_i = 1'b1;
        for (int i = 0; i < 30 && cke_o; i++) step();
        sr_req_i = 1'b0;
        low = cke_o ? 0 : 1;
        step();
        while (!cke_o && low < 100) begin
            low++;
            step();
        end
        check(low == TRAS_CYC + 1, "R9", "clock enable low cycles", low, TRAS_CYC + 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule